// File: doc/BRIEF.md
# Three-Port Arbitrated Scratchpad RAM

This block is a single-bank on-chip scratchpad shared by three request ports. Port 2 serves external system-bus masters. Port 1 serves the CPU's internal path, which carries instruction fetches and operand writes. Port 0 serves CPU operand reads. In every clock a fixed-priority arbiter grants at most one pending request. A port that loses keeps its request asserted and waits. Nothing is dropped.

Each granted access is first checked against a fixed 128 KB address window. Virtual and physical addresses are the same. The two CPU-side ports must also pass a privilege test: the access proceeds when the privileged-mode input is 1, or when the user-access enable input is 1. The system-bus port is checked against the window only.

- A permitted access raises a non-cacheable indication in its grant cycle and goes to the storage array.
- A rejected access leaves the array untouched and returns an error response.

Every response arrives one clock after its grant.

Top module: `scratch3_ram`

## Requirements
- R1: An address hits when 0xE55F_0000 <= addr <= 0xE560_FFFF, both bounds inclusive. `noncache` is high in exactly those cycles where the granted access is a permitted hit.
- R2: At most one bit of `ready` is high per cycle, and only for a port whose `req_valid` bit is high. A port that is not granted keeps its request pending.
- R3: Priority is fixed by port index: port 2 (system bus) is served before port 1 (internal), and port 1 is served before port 0 (operand read).
- R4: A request held continuously on port 0 is granted in the first cycle in which ports 1 and 2 have `req_valid` low.
- R5: On ports 0 and 1, an access is permitted only when `priv_mode`=1 or `user_en`=1. Otherwise it is rejected.
- R6: Port 2 ignores `priv_mode` and `user_en`. Only its address is decoded.
- R7: A rejected access (window miss or failed mode test) produces `rsp_valid` with `rsp_err`=1 on its port one cycle after the grant, and it does not change the array.
- R8: One cycle after every grant, `rsp_valid` pulses on the granted port only. For a permitted read, `rsp_rdata` then holds the stored word.
- R9: A write updates byte k (bits 8k+7:8k) only when `req_be[4p+k]`=1.
- R10: The array word is selected by bits [IDX_W+1:2] of (addr - 0xE55F_0000), where IDX_W = log2(DEPTH). With the default DEPTH of 1024, addresses 4096 bytes apart alias.
- R11: While `rst` is high and in the first cycle after it, `ready`, `rsp_valid` and `noncache` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| priv_mode | input | 1 | CPU privileged-mode flag |
| user_en | input | 1 | Enables CPU access to the window in user mode |
| req_valid | input | 3 | Request pending, one bit per port (2=system, 1=internal, 0=operand) |
| req_write | input | 3 | 1 = write, 0 = read, per port |
| req_addr | input | 96 | Byte address, port p in bits [32p+31:32p] |
| req_wdata | input | 96 | Write data, port p in bits [32p+31:32p] |
| req_be | input | 12 | Byte enables, port p in bits [4p+3:4p] |
| ready | output | 3 | Grant; the request is taken at this clock edge |
| rsp_valid | output | 3 | Response strobe, one cycle after grant |
| rsp_err | output | 3 | Response is an error (miss or mode reject) |
| rsp_rdata | output | 32 | Read data of the responding port |
| noncache | output | 1 | Granted access is a permitted non-cacheable hit |

## Verification
A wrong arbitration state appears at once as a `ready` pattern that disagrees with the priority rule in the same combinational cycle. A faulty decode or privilege gate shows one cycle later as a wrong `rsp_err`. A corrupted array word, a byte lane written without its enable, or a write that a rejection should have blocked stays hidden until that word is read again. The bench therefore preloads every word and later reads through aliases and after rejected writes, so such faults surface within the next read of the affected index.

// File: rtl/s3r_pkg.sv
package s3r_pkg;

  localparam int NPORT = 3;

  typedef enum logic [1:0] {
    PORT_OPR = 2'd0,
    PORT_INT = 2'd1,
    PORT_SYS = 2'd2
  } port_e;

  // Inclusive window test.
  function automatic logic in_window(logic [31:0] a, logic [31:0] lo, logic [31:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  // Word offset from the window base.
  function automatic logic [31:0] word_of(logic [31:0] a, logic [31:0] lo);
    return (a - lo) >> 2;
  endfunction

  // CPU-side permission: privileged, or user access enabled.
  function automatic logic mode_allows(logic priv, logic uen);
    return priv | uen;
  endfunction

endpackage

// File: rtl/s3r_prio_arb.sv
module s3r_prio_arb #(
  parameter int N = 3
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  // Highest index wins.
  for (genvar i = 0; i < N; i++) begin : g_lane
    if (i == N-1) begin : g_top
      assign gnt[i] = req[i];
    end else begin : g_low
      assign gnt[i] = req[i] & ~(|req[N-1:i+1]);
    end
  end
endmodule

// File: rtl/s3r_gate.sv
module s3r_gate #(
  parameter logic [31:0] BASE       = 32'hE55F_0000,
  parameter logic [31:0] LAST       = 32'hE560_FFFF,
  parameter bit          CHECK_MODE = 1'b1
) (
  input  logic [31:0] addr,
  input  logic        priv_mode,
  input  logic        user_en,
  output logic        ok
);
  logic hit;
  assign hit = s3r_pkg::in_window(addr, BASE, LAST);

  if (CHECK_MODE) begin : g_cpu
    assign ok = hit & s3r_pkg::mode_allows(priv_mode, user_en);
  end else begin : g_bus
    assign ok = hit;
  end
endmodule

// File: rtl/s3r_bank.sv
module s3r_bank #(
  parameter int DEPTH  = 1024,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BE_W-1:0]   be,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int k = 0; k < BE_W; k++) begin
        if (be[k]) mem[idx][k*8 +: 8] <= wdata[k*8 +: 8];
      end
    end
    if (re) rdata <= mem[idx];
  end
endmodule

// File: rtl/scratch3_ram.sv
module scratch3_ram #(
  parameter int          DEPTH     = 1024,
  parameter logic [31:0] WIN_BASE  = 32'hE55F_0000,
  parameter int          WIN_BYTES = 131072,
  localparam int          N        = s3r_pkg::NPORT,
  localparam int          AW       = 32,
  localparam int          DW       = 32,
  localparam int          BW       = DW / 8,
  localparam int          IDX_W    = $clog2(DEPTH),
  localparam logic [31:0] WIN_LAST = WIN_BASE + WIN_BYTES - 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            priv_mode,
  input  logic            user_en,
  input  logic [N-1:0]    req_valid,
  input  logic [N-1:0]    req_write,
  input  logic [N*AW-1:0] req_addr,
  input  logic [N*DW-1:0] req_wdata,
  input  logic [N*BW-1:0] req_be,
  output logic [N-1:0]    ready,
  output logic [N-1:0]    rsp_valid,
  output logic [N-1:0]    rsp_err,
  output logic [DW-1:0]   rsp_rdata,
  output logic            noncache
);
  logic [N-1:0]     req_live;
  logic [N-1:0]     gate_ok;
  logic [AW-1:0]    sel_addr;
  logic [DW-1:0]    sel_wdata;
  logic [BW-1:0]    sel_be;
  logic             sel_we;
  logic             grant_ok;
  logic             mem_we;
  logic             mem_re;
  logic [IDX_W-1:0] mem_idx;

  assign req_live = req_valid & {N{~rst}};

  s3r_prio_arb #(.N(N)) u_arb (
    .req(req_live),
    .gnt(ready)
  );

  for (genvar g = 0; g < N; g++) begin : g_gate
    s3r_gate #(
      .BASE      (WIN_BASE),
      .LAST      (WIN_LAST),
      .CHECK_MODE(g != N-1)
    ) u_gate (
      .addr     (req_addr[g*AW +: AW]),
      .priv_mode(priv_mode),
      .user_en  (user_en),
      .ok       (gate_ok[g])
    );
  end

  always_comb begin
    sel_addr  = '0;
    sel_wdata = '0;
    sel_be    = '0;
    sel_we    = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (ready[i]) begin
        sel_addr  = req_addr[i*AW +: AW];
        sel_wdata = req_wdata[i*DW +: DW];
        sel_be    = req_be[i*BW +: BW];
        sel_we    = req_write[i];
      end
    end
  end

  assign grant_ok = |(ready & gate_ok);
  assign mem_we   = grant_ok & sel_we;
  assign mem_re   = grant_ok & ~sel_we;
  assign mem_idx  = IDX_W'(s3r_pkg::word_of(sel_addr, WIN_BASE));
  assign noncache = grant_ok;

  s3r_bank #(.DEPTH(DEPTH), .DATA_W(DW)) u_bank (
    .clk  (clk),
    .we   (mem_we),
    .re   (mem_re),
    .idx  (mem_idx),
    .be   (sel_be),
    .wdata(sel_wdata),
    .rdata(rsp_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= '0;
      rsp_err   <= '0;
    end else begin
      rsp_valid <= ready;
      rsp_err   <= ready & ~gate_ok;
    end
  end
endmodule

// File: rtl/s3r_chk.sv
module s3r_chk #(
  parameter int N = 3
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] req_valid,
  input logic [N-1:0] ready,
  input logic [N-1:0] rsp_valid,
  input logic [N-1:0] gate_ok,
  input logic         noncache,
  input logic         mem_we
);
  // R2
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(ready));
  // R2
  gnt_needs_req_chk: assert property (@(posedge clk) disable iff (rst) (ready & ~req_valid) == '0);
  // R3
  sys_first_chk: assert property (@(posedge clk) disable iff (rst) req_valid[2] |-> ready[2]);
  // R3
  int_second_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid[1] && !req_valid[2]) |-> ready[1]);
  // R4
  opr_served_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid[0] && req_valid[2:1] == 2'b00) |-> ready[0]);
  // R8
  rsp_follows_chk: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> rsp_valid == $past(ready));
  // R1
  nc_on_grant_chk: assert property (@(posedge clk) disable iff (rst) noncache |-> (ready & gate_ok) != '0);
  // R7
  no_write_on_err_chk: assert property (@(posedge clk) disable iff (rst) mem_we |-> (ready & gate_ok) != '0);
endmodule

bind scratch3_ram s3r_chk #(.N(3)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .ready    (ready),
  .rsp_valid(rsp_valid),
  .gate_ok  (gate_ok),
  .noncache (noncache),
  .mem_we   (mem_we)
);

// File: tb/test_scratch3_ram.sv
module test_scratch3_ram;
  localparam int          DEPTH = 1024;
  localparam logic [31:0] BASE  = 32'hE55F_0000;
  localparam logic [31:0] LAST  = 32'hE560_FFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        priv_mode = 1'b0;
  logic        user_en = 1'b0;
  logic [2:0]  req_valid, req_write, ready, rsp_valid, rsp_err;
  logic [95:0] req_addr, req_wdata;
  logic [11:0] req_be;
  logic [31:0] rsp_rdata;
  logic        noncache;

  logic        p_vld [3];
  logic        p_we  [3];
  logic [31:0] p_addr[3];
  logic [31:0] p_wd  [3];
  logic [3:0]  p_be  [3];
  logic [31:0] model [DEPTH];

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < 3; i++) begin
      req_valid[i]         = p_vld[i];
      req_write[i]         = p_we[i];
      req_addr[i*32 +: 32] = p_addr[i];
      req_wdata[i*32 +: 32] = p_wd[i];
      req_be[i*4 +: 4]     = p_be[i];
    end
  end

  scratch3_ram i_scratch3_ram (
    .clk(clk), .rst(rst), .priv_mode(priv_mode), .user_en(user_en),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .ready(ready),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .noncache(noncache)
  );

  function automatic int idx_of(logic [31:0] a);
    logic [31:0] off = a - BASE;
    return int'(off[11:2]);
  endfunction

  function automatic logic allowed(int p, logic [31:0] a, logic pm, logic ue);
    logic hit = (a >= BASE) && (a <= LAST);
    if (p == 2) return hit;
    return hit && (pm || ue);
  endfunction

  function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] nw, logic [3:0] be);
    logic [31:0] r = old;
    for (int k = 0; k < 4; k++) if (be[k]) r[k*8 +: 8] = nw[k*8 +: 8];
    return r;
  endfunction

  task automatic chk(logic cond, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic set_req(int p, logic we, logic [31:0] a, logic [31:0] d, logic [3:0] be);
    p_vld[p] = 1'b1; p_we[p] = we; p_addr[p] = a; p_wd[p] = d; p_be[p] = be;
  endtask

  // Called just after a negedge with inputs settled.
  task automatic run_cycle(output int win, output logic got_err);
    int w;
    logic ok, rd;
    logic [2:0] exp_rdy;
    logic [31:0] exp_rd;
    #1;
    w = -1;
    for (int i = 2; i >= 0; i--) if (p_vld[i] && w < 0) w = i;
    exp_rdy = (w < 0) ? 3'b000 : 3'(1 << w);
    chk(ready == exp_rdy, "R3", 32'(ready), 32'(exp_rdy));
    ok = (w >= 0) && allowed(w, p_addr[w], priv_mode, user_en);
    chk(noncache == ok, "R1", 32'(noncache), 32'(ok));
    rd = ok && !p_we[w];
    exp_rd = 32'h0;
    if (ok && p_we[w]) model[idx_of(p_addr[w])] = merge(model[idx_of(p_addr[w])], p_wd[w], p_be[w]);
    if (rd) exp_rd = model[idx_of(p_addr[w])];
    @(posedge clk);
    @(negedge clk);
    if (w >= 0) p_vld[w] = 1'b0;
    chk(rsp_valid == exp_rdy, "R8", 32'(rsp_valid), 32'(exp_rdy));
    got_err = 1'b0;
    if (w >= 0) begin
      got_err = rsp_err[w];
      chk(rsp_err == (ok ? 3'b000 : exp_rdy), "R7", 32'(rsp_err), 32'(ok ? 3'b000 : exp_rdy));
    end
    if (rd) chk(rsp_rdata == exp_rd, "R8", rsp_rdata, exp_rd);
    win = w;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int w;
    logic e;
    logic [31:0] a;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 3; i++) begin
      p_vld[i] = 1'b0; p_we[i] = 1'b0; p_addr[i] = '0; p_wd[i] = '0; p_be[i] = '0;
    end
    // Request held during reset must not be granted
    set_req(2, 1'b0, BASE, 32'h0, 4'hF);
    repeat (3) @(negedge clk);
    chk(ready == 3'b000, "R11", 32'(ready), 32'h0);
    chk(rsp_valid == 3'b000, "R11", 32'(rsp_valid), 32'h0);
    chk(noncache == 1'b0, "R11", 32'(noncache), 32'h0);
    p_vld[2] = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    chk(rsp_valid == 3'b000 && noncache == 1'b0, "R11", 32'(rsp_valid), 32'h0);

    // Preload through system port with CPU access disabled
    priv_mode = 1'b0; user_en = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      set_req(2, 1'b1, BASE + 32'(i*4), $urandom, 4'hF);
      run_cycle(w, e);
      chk(e == 1'b0, "R6", 32'(e), 32'h0);
    end
    // System-port read with mode gate closed
    set_req(2, 1'b0, BASE + 32'h10, 32'h0, 4'h0);
    run_cycle(w, e);
    chk(e == 1'b0, "R6", 32'(e), 32'h0);

    // Simultaneous requests: served 2, then 1, then 0
    priv_mode = 1'b1;
    set_req(0, 1'b0, BASE + 32'h20, 32'h0, 4'h0);
    set_req(1, 1'b0, BASE + 32'h24, 32'h0, 4'h0);
    set_req(2, 1'b0, BASE + 32'h28, 32'h0, 4'h0);
    run_cycle(w, e); chk(w == 2, "R3", 32'(w), 32'd2);
    run_cycle(w, e); chk(w == 1, "R3", 32'(w), 32'd1);
    run_cycle(w, e); chk(w == 0, "R4", 32'(w), 32'd0);

    // Starvation: port 0 held while higher ports keep refilling
    set_req(0, 1'b0, BASE + 32'h40, 32'h0, 4'h0);
    for (int k = 0; k < 4; k++) begin
      set_req(2, 1'b0, BASE + 32'(k*4), 32'h0, 4'h0);
      set_req(1, 1'b0, BASE + 32'(k*8), 32'h0, 4'h0);
      run_cycle(w, e); chk(w == 2, "R2", 32'(w), 32'd2);
      run_cycle(w, e); chk(w == 1, "R2", 32'(w), 32'd1);
    end
    run_cycle(w, e); chk(w == 0, "R4", 32'(w), 32'd0);

    // Window boundaries on internal port
    set_req(1, 1'b0, BASE - 32'd4, 32'h0, 4'h0); run_cycle(w, e); chk(e == 1'b1, "R1", 32'(e), 32'h1);
    set_req(1, 1'b0, BASE, 32'h0, 4'h0);         run_cycle(w, e); chk(e == 1'b0, "R1", 32'(e), 32'h0);
    set_req(1, 1'b0, LAST - 32'd3, 32'h0, 4'h0); run_cycle(w, e); chk(e == 1'b0, "R1", 32'(e), 32'h0);
    set_req(1, 1'b0, LAST + 32'd1, 32'h0, 4'h0); run_cycle(w, e); chk(e == 1'b1, "R1", 32'(e), 32'h1);
    set_req(2, 1'b0, LAST + 32'd1, 32'h0, 4'h0); run_cycle(w, e); chk(e == 1'b1, "R6", 32'(e), 32'h1);

    // Mode gate
    priv_mode = 1'b0; user_en = 1'b0;
    set_req(0, 1'b0, BASE + 32'h80, 32'h0, 4'h0); run_cycle(w, e); chk(e == 1'b1, "R5", 32'(e), 32'h1);
    set_req(1, 1'b1, BASE + 32'h80, 32'hDEAD_BEEF, 4'hF); run_cycle(w, e); chk(e == 1'b1, "R5", 32'(e), 32'h1);
    user_en = 1'b1;
    set_req(0, 1'b0, BASE + 32'h80, 32'h0, 4'h0); run_cycle(w, e); chk(e == 1'b0, "R5", 32'(e), 32'h0);
    chk(rsp_rdata == model[idx_of(BASE + 32'h80)], "R7", rsp_rdata, model[idx_of(BASE + 32'h80)]);

    // Byte enables
    set_req(2, 1'b1, BASE + 32'h100, 32'h1122_3344, 4'hF); run_cycle(w, e);
    set_req(1, 1'b1, BASE + 32'h100, 32'hAABB_CCDD, 4'b0101); run_cycle(w, e);
    set_req(0, 1'b0, BASE + 32'h100, 32'h0, 4'h0); run_cycle(w, e);
    chk(rsp_rdata == 32'h11BB_33DD, "R9", rsp_rdata, 32'h11BB_33DD);

    // Aliasing one DEPTH*4 bytes apart
    set_req(2, 1'b1, BASE + 32'h8, 32'hCAFE_0123, 4'hF); run_cycle(w, e);
    set_req(0, 1'b0, BASE + 32'h8 + 32'(DEPTH*4) + 32'h0001_0000, 32'h0, 4'h0); run_cycle(w, e);
    chk(rsp_rdata == 32'hCAFE_0123, "R10", rsp_rdata, 32'hCAFE_0123);

    // Constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      priv_mode = ($urandom % 4) != 0;
      user_en   = $urandom % 2;
      for (int p = 0; p < 3; p++) begin
        if (!p_vld[p] && ($urandom % 10) < 4) begin
          case ($urandom % 10)
            7:       a = BASE - 32'd4;
            8:       a = LAST + 32'd1 + 32'(($urandom % 8) * 4);
            9:       a = LAST - 32'd3;
            default: a = BASE + 32'(($urandom % 512) * 4) + (($urandom % 2) != 0 ? 32'h0001_0000 : 32'h0);
          endcase
          set_req(p, ($urandom % 2) != 0, a, $urandom, 4'($urandom));
        end
      end
      run_cycle(w, e);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) cyc <= cyc + 1;
endmodule